// File: doc/BRIEF.md
# Clock Level Divider Selector

This block picks the best source clock level and integer divider for a requested output frequency. Software fills a table of up to `NUM_LEVELS` source frequencies and sets how many of them are valid. A start pulse with a requested frequency then begins a sequential search. For each level the block takes the smallest divider that brings that level at or below the request, then measures how far the divided result falls short. It keeps the level with the smallest shortfall.

The search stops as soon as a level divides down to the request exactly. In exact mode, a table with no such level ends in an error. In the normal mode, the closest level from below is reported. The result is the chosen index, that level's frequency and an error flag, qualified by a one-cycle done pulse. One shared restoring divider does all the arithmetic, two divisions per level.

Top module: `clk_level_pick`

## Requirements
- R1: After reset, `done` and `err` are 0, and `sel_idx` and `sel_freq` are 0.
- R2: A table write stores `tbl_wr_data` at entry `tbl_wr_addr`. A count write sets the valid level count to `cnt_wr_data`. A count above `NUM_LEVELS` saturates to `NUM_LEVELS`.
- R3: For level frequency f and request r, the divider is d = ceil(f / r). A level of 0 uses d = 1. The level error is r − floor(f / d).
- R4: A level becomes the new best only if its error is strictly smaller than the current best error. The best error starts at all ones, so the lowest index wins a tie.
- R5: A level with zero error ends the search at once with `err` = 0 and that level's index. Later levels are not examined.
- R6: A start with `req_freq` = 0, or with a valid level count of 0, ends with `err` = 1 and no search. `done` comes one clock edge after the start edge.
- R7: When all valid levels are examined without a zero error, exact mode (`exact_mode` = 1 at start) ends with `err` = 1. Normal mode reports the best level with `err` = 0. It reports `err` = 1 only if no level had an error below all ones.
- R8: When `err` = 1, `sel_idx` and `sel_freq` are 0. When `err` = 0, `sel_freq` equals the table entry at `sel_idx`.
- R9: `done` is high for exactly one cycle. `sel_idx`, `sel_freq` and `err` change only on the edge that raises `done`, and hold until the next result.
- R10: For a search that examines n levels, `done` is first seen high after (2·FREQ_W+3)·n + 1 rising edges, counting the edge that samples `start`. With the default width this is 67·n + 1.
- R11: A `start` pulse while a search is running is ignored. The running search's result and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Table entry write strobe |
| tbl_wr_addr | input | $clog2(NUM_LEVELS) | Table entry index to write |
| tbl_wr_data | input | FREQ_W | Level frequency to store |
| cnt_wr_en | input | 1 | Valid level count write strobe |
| cnt_wr_data | input | $clog2(NUM_LEVELS+1) | Valid level count value |
| start | input | 1 | Begins a search when idle |
| req_freq | input | FREQ_W | Requested output frequency, sampled with start |
| exact_mode | input | 1 | Requires a zero-error level, sampled with start |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Search failed |
| sel_idx | output | $clog2(NUM_LEVELS) | Chosen level index |
| sel_freq | output | FREQ_W | Chosen level frequency |

## Verification
The rejected starts of R6 give `done` one edge after the start edge. Every real search gives it (2·FREQ_W+3) edges per examined level later, plus that one. The bench computes the examined-level count from its own model of the search, including the early exit on a zero error. It then counts rising edges from the start edge to the first falling-edge sample that shows `done` high, and compares that count exactly. All outputs are sampled on falling edges. The cycle after each result is checked for `done` low with the outputs unchanged.

// File: rtl/clk_lvl_pkg.sv
package clk_lvl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_QUOT  = 2'd2,
    ST_TRUNC = 2'd3
  } srch_st_e;

endpackage

// File: rtl/clk_lvl_table.sv
module clk_lvl_table #(
  parameter int NUM_LEVELS = 32,
  parameter int FREQ_W     = 32,
  localparam int IDX_W     = $clog2(NUM_LEVELS),
  localparam int CNT_W     = $clog2(NUM_LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [FREQ_W-1:0] wr_data,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [FREQ_W-1:0] rd_data,
  output logic [CNT_W-1:0]  lvl_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_LEVELS);

  logic [FREQ_W-1:0] ent_q [NUM_LEVELS];
  logic [CNT_W-1:0]  cnt_q, cnt_n;

  // One register per level, each with its own write enable
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_addr == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[g] <= '0;
      else if (ent_en) ent_q[g] <= wr_data;
    end
  end

  // Count saturates at the table depth
  always_comb begin
    cnt_n = (cnt_wdata > CNT_MAX) ? CNT_MAX : cnt_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_n;
  end

  assign rd_data   = ent_q[rd_idx];
  assign lvl_count = cnt_q;

endmodule

// File: rtl/clk_lvl_divu.sv
module clk_lvl_divu #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  logic [W-1:0]  rem_q, rem_n;
  logic [W-1:0]  quo_q, quo_n;
  logic [W-1:0]  dsr_q, dsr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n;
  logic          done_q, done_n;
  logic [W+1:0]  trial;

  // One quotient bit per cycle, restoring form
  always_comb begin
    rem_n  = rem_q;
    quo_n  = quo_q;
    dsr_n  = dsr_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    trial  = {1'b0, rem_q, quo_q[W-1]} - {2'b00, dsr_q};
    if (start) begin
      rem_n  = '0;
      quo_n  = dividend;
      dsr_n  = divisor;
      cnt_n  = CW'(W);
      busy_n = 1'b1;
    end else if (busy_q) begin
      if (!trial[W+1]) begin
        rem_n = trial[W-1:0];
        quo_n = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_n = {rem_q[W-2:0], quo_q[W-1]};
        quo_n = {quo_q[W-2:0], 1'b0};
      end
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      dsr_q  <= dsr_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;

endmodule

// File: rtl/clk_lvl_search.sv
module clk_lvl_search
  import clk_lvl_pkg::*;
#(
  parameter int NUM_LEVELS = 32,
  parameter int FREQ_W     = 32,
  localparam int IDX_W     = $clog2(NUM_LEVELS),
  localparam int CNT_W     = $clog2(NUM_LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] req_freq,
  input  logic              exact_mode,
  input  logic [CNT_W-1:0]  lvl_count,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [FREQ_W-1:0] rd_data,
  output logic              dv_start,
  output logic [FREQ_W-1:0] dv_dividend,
  output logic [FREQ_W-1:0] dv_divisor,
  input  logic              dv_done,
  input  logic [FREQ_W-1:0] dv_quot,
  input  logic [FREQ_W-1:0] dv_rem,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [FREQ_W-1:0] sel_freq
);

  srch_st_e          st_q, st_n;
  logic [FREQ_W-1:0] req_q, req_n;
  logic              exact_q, exact_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [FREQ_W-1:0] fcur_q, fcur_n;
  logic [FREQ_W-1:0] berr_q, berr_n;
  logic [IDX_W-1:0]  bidx_q, bidx_n;
  logic [FREQ_W-1:0] bfreq_q, bfreq_n;
  logic              found_q, found_n;
  logic              done_q, done_n;
  logic              err_q, err_n;
  logic [IDX_W-1:0]  sidx_q, sidx_n;
  logic [FREQ_W-1:0] sfreq_q, sfreq_n;
  logic              res_en;

  logic [FREQ_W-1:0] ceil_div, step_div, lvl_err;
  logic              better, last_lvl, fail;

  // Ceiling divider from the first division; a zero level uses one
  always_comb begin
    ceil_div = dv_quot + {{(FREQ_W-1){1'b0}}, (dv_rem != '0)};
    step_div = (ceil_div == '0) ? {{(FREQ_W-1){1'b0}}, 1'b1} : ceil_div;
    lvl_err  = req_q - dv_quot;
    better   = lvl_err < berr_q;
    last_lvl = (CNT_W'(idx_q) + 1'b1) == cnt_q;
    fail     = exact_q || !(found_q || better);
  end

  assign rd_idx      = idx_q;
  assign dv_start    = (st_q == ST_LOAD) || ((st_q == ST_QUOT) && dv_done);
  assign dv_dividend = (st_q == ST_LOAD) ? rd_data : fcur_q;
  assign dv_divisor  = (st_q == ST_QUOT) ? step_div : req_q;

  always_comb begin
    st_n    = st_q;
    req_n   = req_q;
    exact_n = exact_q;
    cnt_n   = cnt_q;
    idx_n   = idx_q;
    fcur_n  = fcur_q;
    berr_n  = berr_q;
    bidx_n  = bidx_q;
    bfreq_n = bfreq_q;
    found_n = found_q;
    done_n  = 1'b0;
    res_en  = 1'b0;
    err_n   = err_q;
    sidx_n  = sidx_q;
    sfreq_n = sfreq_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if ((req_freq == '0) || (lvl_count == '0)) begin
            res_en  = 1'b1;
            err_n   = 1'b1;
            sidx_n  = '0;
            sfreq_n = '0;
          end else begin
            req_n   = req_freq;
            exact_n = exact_mode;
            cnt_n   = lvl_count;
            idx_n   = '0;
            berr_n  = '1;
            found_n = 1'b0;
            st_n    = ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        fcur_n = rd_data;
        st_n   = ST_QUOT;
      end
      ST_QUOT: begin
        if (dv_done) st_n = ST_TRUNC;
      end
      ST_TRUNC: begin
        if (dv_done) begin
          if (lvl_err == '0) begin
            res_en  = 1'b1;
            err_n   = 1'b0;
            sidx_n  = idx_q;
            sfreq_n = fcur_q;
            st_n    = ST_IDLE;
          end else if (last_lvl) begin
            res_en  = 1'b1;
            err_n   = fail;
            sidx_n  = fail ? '0 : (better ? idx_q : bidx_q);
            sfreq_n = fail ? '0 : (better ? fcur_q : bfreq_q);
            st_n    = ST_IDLE;
          end else begin
            if (better) begin
              berr_n  = lvl_err;
              bidx_n  = idx_q;
              bfreq_n = fcur_q;
              found_n = 1'b1;
            end
            idx_n = idx_q + 1'b1;
            st_n  = ST_LOAD;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
    done_n = res_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      req_q   <= '0;
      exact_q <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      fcur_q  <= '0;
      berr_q  <= '1;
      bidx_q  <= '0;
      bfreq_q <= '0;
      found_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      req_q   <= req_n;
      exact_q <= exact_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      fcur_q  <= fcur_n;
      berr_q  <= berr_n;
      bidx_q  <= bidx_n;
      bfreq_q <= bfreq_n;
      found_q <= found_n;
      done_q  <= done_n;
    end
  end

  // Result registers load only on completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      sidx_q  <= '0;
      sfreq_q <= '0;
    end else if (res_en) begin
      err_q   <= err_n;
      sidx_q  <= sidx_n;
      sfreq_q <= sfreq_n;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign sel_idx  = sidx_q;
  assign sel_freq = sfreq_q;

endmodule

// File: rtl/clk_level_pick.sv
module clk_level_pick #(
  parameter int NUM_LEVELS = 32,
  parameter int FREQ_W     = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tbl_wr_en,
  input  logic [$clog2(NUM_LEVELS)-1:0]    tbl_wr_addr,
  input  logic [FREQ_W-1:0]                tbl_wr_data,
  input  logic                             cnt_wr_en,
  input  logic [$clog2(NUM_LEVELS+1)-1:0]  cnt_wr_data,
  input  logic                             start,
  input  logic [FREQ_W-1:0]                req_freq,
  input  logic                             exact_mode,
  output logic                             done,
  output logic                             err,
  output logic [$clog2(NUM_LEVELS)-1:0]    sel_idx,
  output logic [FREQ_W-1:0]                sel_freq
);

  localparam int IDX_W = $clog2(NUM_LEVELS);
  localparam int CNT_W = $clog2(NUM_LEVELS + 1);

  logic [IDX_W-1:0]  rd_idx;
  logic [FREQ_W-1:0] rd_data;
  logic [CNT_W-1:0]  lvl_count;
  logic              dv_start, dv_done;
  logic [FREQ_W-1:0] dv_dividend, dv_divisor, dv_quot, dv_rem;
  logic              srch_busy;

  clk_lvl_table #(
    .NUM_LEVELS (NUM_LEVELS),
    .FREQ_W     (FREQ_W)
  ) i_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_wr_en),
    .wr_addr   (tbl_wr_addr),
    .wr_data   (tbl_wr_data),
    .cnt_we    (cnt_wr_en),
    .cnt_wdata (cnt_wr_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .lvl_count (lvl_count)
  );

  clk_lvl_divu #(
    .W (FREQ_W)
  ) i_divu (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (dv_start),
    .dividend  (dv_dividend),
    .divisor   (dv_divisor),
    .done      (dv_done),
    .quotient  (dv_quot),
    .remainder (dv_rem)
  );

  clk_lvl_search #(
    .NUM_LEVELS (NUM_LEVELS),
    .FREQ_W     (FREQ_W)
  ) i_search (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .req_freq    (req_freq),
    .exact_mode  (exact_mode),
    .lvl_count   (lvl_count),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .dv_start    (dv_start),
    .dv_dividend (dv_dividend),
    .dv_divisor  (dv_divisor),
    .dv_done     (dv_done),
    .dv_quot     (dv_quot),
    .dv_rem      (dv_rem),
    .busy        (srch_busy),
    .done        (done),
    .err         (err),
    .sel_idx     (sel_idx),
    .sel_freq    (sel_freq)
  );

endmodule

// File: rtl/clk_level_pick_chk.sv
module clk_level_pick_chk #(
  parameter int NUM_LEVELS = 32,
  parameter int FREQ_W     = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          start,
  input logic [FREQ_W-1:0]             req_freq,
  input logic                          busy,
  input logic                          done,
  input logic                          err,
  input logic [$clog2(NUM_LEVELS)-1:0] sel_idx,
  input logic [FREQ_W-1:0]             sel_freq
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(err) && $stable(sel_idx) && $stable(sel_freq)));

  // R8
  err_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ((sel_idx == '0) && (sel_freq == '0)));

  // R6
  zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (req_freq == '0)) |=> (done && err));

  // R11
  idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind clk_level_pick clk_level_pick_chk #(
  .NUM_LEVELS (NUM_LEVELS),
  .FREQ_W     (FREQ_W)
) i_clk_level_pick_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .req_freq (req_freq),
  .busy     (srch_busy),
  .done     (done),
  .err      (err),
  .sel_idx  (sel_idx),
  .sel_freq (sel_freq)
);

// File: tb/test_clk_level_pick.sv
module test_clk_level_pick;

  localparam int NL    = 32;
  localparam int FW    = 32;
  localparam int IW    = $clog2(NL);
  localparam int CW    = $clog2(NL + 1);
  localparam int PER_L = 2 * FW + 3;

  logic          clk;
  logic          rst_n;
  logic          tbl_wr_en;
  logic [IW-1:0] tbl_wr_addr;
  logic [FW-1:0] tbl_wr_data;
  logic          cnt_wr_en;
  logic [CW-1:0] cnt_wr_data;
  logic          start;
  logic [FW-1:0] req_freq;
  logic          exact_mode;
  logic          done;
  logic          err;
  logic [IW-1:0] sel_idx;
  logic [FW-1:0] sel_freq;

  int checks;
  int errors;

  bit [31:0] m_tbl [NL];
  int        m_cnt;

  clk_level_pick #(.NUM_LEVELS(NL), .FREQ_W(FW)) i_clk_level_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .tbl_wr_en   (tbl_wr_en),
    .tbl_wr_addr (tbl_wr_addr),
    .tbl_wr_data (tbl_wr_data),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_data (cnt_wr_data),
    .start       (start),
    .req_freq    (req_freq),
    .exact_mode  (exact_mode),
    .done        (done),
    .err         (err),
    .sel_idx     (sel_idx),
    .sel_freq    (sel_freq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model of the search
  task automatic model(input bit [31:0] r, input bit ex, output bit e_err,
                       output int e_idx, output bit [31:0] e_freq, output int e_n);
    bit [31:0] best, q, d, le;
    bit        found;
    int        bi;
    e_err = 1'b1; e_idx = 0; e_freq = '0; e_n = 0;
    if (r == 0 || m_cnt == 0) return;
    best = '1; found = 1'b0; bi = 0;
    for (int i = 0; i < m_cnt; i++) begin
      q = m_tbl[i] / r;
      d = q + ((m_tbl[i] % r) != 0 ? 32'd1 : 32'd0);
      if (d == 0) d = 1;
      le = r - m_tbl[i] / d;
      e_n = i + 1;
      if (le < best) begin best = le; bi = i; found = 1'b1; end
      if (le == 0) begin
        e_err = 1'b0; e_idx = i; e_freq = m_tbl[i];
        return;
      end
    end
    if (ex || !found) return;
    e_err = 1'b0; e_idx = bi; e_freq = m_tbl[bi];
  endtask

  task automatic wr_tbl(input int a, input bit [31:0] v);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_addr = IW'(a); tbl_wr_data = v;
    @(negedge clk);
    tbl_wr_en = 1'b0;
    m_tbl[a] = v;
  endtask

  task automatic wr_cnt(input int v);
    @(negedge clk);
    cnt_wr_en = 1'b1; cnt_wr_data = CW'(v);
    @(negedge clk);
    cnt_wr_en = 1'b0;
    m_cnt = (v > NL) ? NL : v;
  endtask

  // Runs one search and checks all results; poke > 0 pulses start again mid-search
  task automatic run(input bit [31:0] r, input bit ex, input int poke, input string tag);
    bit        e_err;
    int        e_idx, e_n, lat, exp_lat;
    bit [31:0] e_freq;
    bit        h_err;
    bit [IW-1:0] h_idx;
    bit [FW-1:0] h_freq;
    model(r, ex, e_err, e_idx, e_freq, e_n);
    exp_lat = PER_L * e_n + 1;
    @(negedge clk);
    start = 1'b1; req_freq = r; exact_mode = ex;
    @(posedge clk); lat = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 5000) begin
      start = (poke > 0 && lat == poke);
      if (start) begin req_freq = 32'd7; exact_mode = ~ex; end
      @(posedge clk); lat++;
      @(negedge clk);
      start = 1'b0;
    end
    chk(done == 1'b1, {tag, " R10 done seen"}, done, 1);
    chk(lat == exp_lat, {tag, " R10 latency"}, lat, exp_lat);
    chk(err == e_err, {tag, " R7 err"}, err, e_err);
    chk(sel_idx == IW'(e_idx), {tag, " R4 index"}, sel_idx, e_idx);
    chk(sel_freq == e_freq, {tag, " R8 freq"}, sel_freq, e_freq);
    h_err = err; h_idx = sel_idx; h_freq = sel_freq;
    @(negedge clk);
    chk(done == 1'b0, {tag, " R9 done one cycle"}, done, 0);
    chk(err == h_err && sel_idx == h_idx && sel_freq == h_freq,
        {tag, " R9 outputs held"}, sel_freq, h_freq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired R10 actual=%0d expected=%0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit [31:0] base;
    checks = 0; errors = 0; m_cnt = 0;
    for (int i = 0; i < NL; i++) m_tbl[i] = '0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tbl_wr_en = 1'b0; tbl_wr_addr = '0; tbl_wr_data = '0;
    cnt_wr_en = 1'b0; cnt_wr_data = '0; start = 1'b0; req_freq = '0; exact_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 1'b0 && err == 1'b0, "R1 reset flags", {done, err}, 0);
    chk(sel_idx == '0 && sel_freq == '0, "R1 reset outputs", sel_freq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 zero count, then zero request
    run(32'd1000, 1'b0, 0, "R6 zero count");
    wr_tbl(0, 32'd100); wr_tbl(1, 32'd250); wr_tbl(2, 32'd300); wr_tbl(3, 32'd150);
    wr_cnt(4);
    run(32'd0, 1'b0, 0, "R6 zero request");

    // R5 exact hit at level 2 stops before level 3; R3 divider values
    run(32'd150, 1'b0, 0, "R5 early exit");
    // R3 / R7 best undershoot, no exact level: 333 -> L0 100 e233, L1 250 e83, L2 300 e33, L3 150 e183
    run(32'd333, 1'b0, 0, "R3 best undershoot");
    run(32'd333, 1'b1, 0, "R7 exact fails");
    // R11 start during search ignored
    run(32'd333, 1'b0, 20, "R11 restart ignored");

    // R4 tie keeps lowest index
    wr_tbl(0, 32'd90); wr_tbl(1, 32'd90); wr_cnt(2);
    run(32'd100, 1'b0, 0, "R4 tie");
    // R3 zero level: error equals request
    wr_tbl(0, 32'd0); wr_tbl(1, 32'd10); wr_cnt(2);
    run(32'd50, 1'b0, 0, "R3 zero level");
    // R7 all-ones request with only zero level: nothing beats all ones
    wr_cnt(1);
    run(32'hFFFF_FFFF, 1'b0, 0, "R7 no best");

    // R2 table fill and saturating count
    for (int i = 0; i < NL; i++) wr_tbl(i, 32'd1000 + 32'(i) * 32'd37);
    wr_tbl(NL - 1, 32'd4000);
    wr_cnt(40);
    run(32'd2000, 1'b1, 0, "R2 count saturates");

    // Constrained random mix
    for (int t = 0; t < 24; t++) begin
      base = 32'd1000 + ($urandom % 32'd100000);
      for (int i = 0; i < NL; i++) begin
        case ($urandom % 4)
          0: m_tbl[i] = base * (32'd1 + $urandom % 8);
          1: m_tbl[i] = base * (32'd1 + $urandom % 8) + ($urandom % 50);
          2: m_tbl[i] = $urandom;
          default: m_tbl[i] = $urandom % (base * 4 + 1);
        endcase
        wr_tbl(i, m_tbl[i]);
      end
      wr_cnt(1 + int'($urandom % NL));
      run(base, 1'(($urandom % 3) == 0), 0, "R3 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule